// File: doc/BRIEF.md
# Dual Timer Bus Interface

This block is the processor-facing side of a pair of independent down-counting timer channels, A and B. It decodes chip select, a 3-bit register address and separate read and write strobes. Through them software can load each channel's 16-bit reload value one byte at a time, write each channel's 8-bit control word, and read each channel's 16-bit snapshot one byte at a time. All values on the 8-bit data bus are plain binary.

The counting logic stays inside each channel and is outside this block. A channel reports a timeout as a one-cycle pulse, and it supplies the snapshot value and its interrupt-enable bit. The interface keeps a shared interrupt status byte with one flag per channel, and it drives a single active-low interrupt line. A flag is acknowledged by writing that channel's own control register. Reading either control address returns the status byte, and that read has no side effect.

Writes take effect on each rising clock edge where chip select and the write strobe are both high. Read data is combinational and stays at zero unless chip select and the read strobe are both high. Address map: 0 = A reload high byte / A snapshot high byte, 1 = A low byte, 2 = A control / status, 3 = B high byte, 4 = B low byte, 5 = B control / status. Codes 6 and 7 are reserved.

Top module: `tmr_bus_if`

## Requirements
- R1: After reset, all reload registers and control registers are 0, `ctrl_wr_o` is 0, the status byte reads 0x00 and `irq_no` is 1.
- R2: A write to address 0 or 1 loads bits 15:8 or bits 7:0 of channel A's reload value (`jam_o[15:0]`). Addresses 3 and 4 do the same for channel B (`jam_o[31:16]`). The other byte stays unchanged.
- R3: A write to address 2 (A) or 5 (B) loads that channel's control byte (A = `ctrl_o[7:0]`, B = `ctrl_o[15:8]`). In the cycle after the write edge, that channel's `ctrl_wr_o` bit is 1 for exactly one cycle.
- R4: A read of address 0/1 returns bits 15:8 / 7:0 of `hold_i[15:0]`. A read of address 3/4 returns the same bytes of `hold_i[31:16]`.
- R5: A read of address 2 or 5 returns the status byte. Bit 7 is channel A's flag, bit 6 is channel B's flag, and bits 5:0 are 0.
- R6: When `timeout_i[c]` is 1 at a clock edge, the channel's status flag is set after that edge, whatever the state of its interrupt enable.
- R7: `irq_no` is 0 exactly when at least one channel has its flag set and its `irq_en_i` bit at 1. Dropping the enable releases the line while the flag stays set.
- R8: A control-register write for a channel clears only that channel's flag. The other channel's flag is unchanged.
- R9: If a timeout and a control write for the same channel fall on the same edge, the flag ends set and the control byte is still loaded.
- R10: Reads of addresses 6 and 7 return 0. Writes to them change no reload value, control byte or flag, and raise no `ctrl_wr_o` bit.
- R11: `rdata_o` is 0 unless `cs_i` and `rd_i` are both 1. A write strobe without `cs_i` changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| hold_i | input | 32 | Snapshot values, A in 15:0, B in 31:16 |
| timeout_i | input | 2 | Timeout pulses, bit 0 = A, bit 1 = B |
| irq_en_i | input | 2 | Interrupt enables, bit 0 = A, bit 1 = B |
| jam_o | output | 32 | Reload values, A in 15:0, B in 31:16 |
| ctrl_o | output | 16 | Control bytes, A in 7:0, B in 15:8 |
| ctrl_wr_o | output | 2 | One-cycle control-write pulses per channel |
| irq_no | output | 1 | Combined interrupt, active low |

## Verification
The bench builds the block with its default parameters: two channels and 8-bit bytes. This gives the full 3-bit address map, including both reserved codes 6 and 7, and puts the two status flags at bits 7 and 6. The timer channels are replaced by bench-driven timeout pulses, enables and snapshot values. This lets the bench force the corners directly: a flag set with its enable off, both flags pending and cleared one at a time, and a timeout on the same edge as the acknowledging control write.

// File: rtl/tbi_pkg.sv
package tbi_pkg;
  typedef enum logic [1:0] {
    SLOT_HI   = 2'd0,
    SLOT_LO   = 2'd1,
    SLOT_CTRL = 2'd2
  } slot_e;

  localparam int unsigned SLOTS_PER_CH = 3;

  function automatic int unsigned slot_code(int unsigned ch, slot_e s);
    return ch * SLOTS_PER_CH + int'(s);
  endfunction
endpackage

// File: rtl/tbi_decode.sv
module tbi_decode import tbi_pkg::*; #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              cs_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rd_en_o,
  output logic [NUM_CH-1:0] wr_hi_o,
  output logic [NUM_CH-1:0] wr_lo_o,
  output logic [NUM_CH-1:0] wr_ctrl_o
);
  logic wr_en;
  assign wr_en   = cs_i & wr_i;
  assign rd_en_o = cs_i & rd_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign wr_hi_o[c]   = wr_en && (addr_i == ADDR_W'(slot_code(c, SLOT_HI)));
    assign wr_lo_o[c]   = wr_en && (addr_i == ADDR_W'(slot_code(c, SLOT_LO)));
    assign wr_ctrl_o[c] = wr_en && (addr_i == ADDR_W'(slot_code(c, SLOT_CTRL)));
  end
endmodule

// File: rtl/tbi_chan_regs.sv
module tbi_chan_regs #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_hi_i,
  input  logic              wr_lo_i,
  input  logic              wr_ctrl_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  jam_o,
  output logic [BYTE_W-1:0] ctrl_o,
  output logic              ctrl_wr_o
);
  logic [CNT_W-1:0]  jam_q;
  logic [BYTE_W-1:0] ctrl_q;
  logic              cwr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      jam_q  <= '0;
      ctrl_q <= '0;
      cwr_q  <= 1'b0;
    end else begin
      if (wr_hi_i)   jam_q[CNT_W-1:BYTE_W] <= wdata_i;
      if (wr_lo_i)   jam_q[BYTE_W-1:0]     <= wdata_i;
      if (wr_ctrl_i) ctrl_q                <= wdata_i;
      cwr_q <= wr_ctrl_i;
    end
  end

  assign jam_o     = jam_q;
  assign ctrl_o    = ctrl_q;
  assign ctrl_wr_o = cwr_q;

  p_jam_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_hi_i || wr_lo_i) |=> $stable(jam_o));
  p_ctrl_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ctrl_i |=> ($stable(ctrl_o) && !ctrl_wr_o));
  p_ctrl_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl_i |=> (ctrl_wr_o && ctrl_o == $past(wdata_i)));
endmodule

// File: rtl/tbi_status.sv
module tbi_status #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] timeout_i,
  input  logic [NUM_CH-1:0] clr_i,
  input  logic [NUM_CH-1:0] irq_en_i,
  output logic [BYTE_W-1:0] status_o,
  output logic              irq_no
);
  logic [NUM_CH-1:0] flag_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_flag
    // set has priority over the acknowledge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           flag_q[c] <= 1'b0;
      else if (timeout_i[c]) flag_q[c] <= 1'b1;
      else if (clr_i[c])     flag_q[c] <= 1'b0;
    end
    assign status_o[BYTE_W-1-c] = flag_q[c];

    p_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      timeout_i[c] |=> status_o[BYTE_W-1-c]);
    p_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[c] && !timeout_i[c]) |=> !status_o[BYTE_W-1-c]);
    p_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i[c] && !timeout_i[c]) |=> $stable(status_o[BYTE_W-1-c]));
  end

  if (BYTE_W > NUM_CH) begin : g_pad
    assign status_o[BYTE_W-NUM_CH-1:0] = '0;
  end

  assign irq_no = ~|(flag_q & irq_en_i);

  p_irq_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i == '0) |-> irq_no);
endmodule

// File: rtl/tbi_rdmux.sv
module tbi_rdmux import tbi_pkg::*; #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned CNT_W = 2 * BYTE_W
) (
  input  logic                    rd_en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [NUM_CH*CNT_W-1:0] hold_i,
  input  logic [BYTE_W-1:0]       status_i,
  output logic [BYTE_W-1:0]       rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      for (int unsigned c = 0; c < NUM_CH; c++) begin
        if (addr_i == ADDR_W'(slot_code(c, SLOT_HI)))
          rdata_o = hold_i[c*CNT_W+BYTE_W +: BYTE_W];
        if (addr_i == ADDR_W'(slot_code(c, SLOT_LO)))
          rdata_o = hold_i[c*CNT_W +: BYTE_W];
        if (addr_i == ADDR_W'(slot_code(c, SLOT_CTRL)))
          rdata_o = status_i;
      end
    end
  end
endmodule

// File: rtl/tmr_bus_if.sv
module tmr_bus_if import tbi_pkg::*; #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W  = 2 * BYTE_W,
  localparam int unsigned ADDR_W = $clog2(NUM_CH * SLOTS_PER_CH)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cs_i,
  input  logic                    rd_i,
  input  logic                    wr_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [BYTE_W-1:0]       wdata_i,
  output logic [BYTE_W-1:0]       rdata_o,
  input  logic [NUM_CH*CNT_W-1:0] hold_i,
  input  logic [NUM_CH-1:0]       timeout_i,
  input  logic [NUM_CH-1:0]       irq_en_i,
  output logic [NUM_CH*CNT_W-1:0] jam_o,
  output logic [NUM_CH*BYTE_W-1:0] ctrl_o,
  output logic [NUM_CH-1:0]       ctrl_wr_o,
  output logic                    irq_no
);
  logic              rd_en;
  logic [NUM_CH-1:0] wr_hi, wr_lo, wr_ctrl;
  logic [BYTE_W-1:0] status;

  tbi_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .cs_i, .wr_i, .rd_i, .addr_i,
    .rd_en_o(rd_en), .wr_hi_o(wr_hi), .wr_lo_o(wr_lo), .wr_ctrl_o(wr_ctrl)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tbi_chan_regs #(.BYTE_W(BYTE_W)) u_regs (
      .clk_i, .rst_ni,
      .wr_hi_i(wr_hi[c]), .wr_lo_i(wr_lo[c]), .wr_ctrl_i(wr_ctrl[c]),
      .wdata_i,
      .jam_o(jam_o[c*CNT_W +: CNT_W]),
      .ctrl_o(ctrl_o[c*BYTE_W +: BYTE_W]),
      .ctrl_wr_o(ctrl_wr_o[c])
    );
  end

  tbi_status #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_stat (
    .clk_i, .rst_ni, .timeout_i, .clr_i(wr_ctrl), .irq_en_i,
    .status_o(status), .irq_no
  );

  tbi_rdmux #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_rd (
    .rd_en_i(rd_en), .addr_i, .hold_i, .status_i(status), .rdata_o
  );

  p_rd_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && rd_i) |-> (rdata_o == '0));
  p_rsvd_wr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && wr_i && int'(addr_i) >= NUM_CH*SLOTS_PER_CH && timeout_i == '0)
    |=> ($stable(jam_o) && $stable(ctrl_o) && ctrl_wr_o == '0 && $stable(status)));
  p_stat_pad_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_i && addr_i == ADDR_W'(slot_code(0, SLOT_CTRL)))
    |-> (rdata_o[BYTE_W-NUM_CH-1:0] == '0));
endmodule

// File: tb/tb_tmr_bus_if.sv
module tb_tmr_bus_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [31:0] hold = '0;
  logic [1:0]  tmo = '0, ien = '0;
  logic [31:0] jam;
  logic [15:0] ctrl;
  logic [1:0]  cwr;
  logic        irq_n;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tmr_bus_if dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .hold_i(hold),
    .timeout_i(tmo), .irq_en_i(ien), .jam_o(jam), .ctrl_o(ctrl),
    .ctrl_wr_o(cwr), .irq_no(irq_n)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = a;
    #1 d = rdata;
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic pulse_tmo(logic [1:0] m);
    @(negedge clk);
    tmo = m;
    @(negedge clk);
    tmo = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 jam", jam, 32'h0);
    chk("R1 ctrl", {16'h0, ctrl}, 32'h0);
    chk("R1 ctrl_wr", {30'h0, cwr}, 32'h0);
    chk("R1 irq", {31'h0, irq_n}, 32'h1);
    bus_rd(3'd2, d);
    chk("R1 status", {24'h0, d}, 32'h0);
  endtask

  task automatic t_jam();
    bus_wr(3'd0, 8'hA5);
    chk("R2 A hi", jam, 32'h0000_A500);
    bus_wr(3'd1, 8'h3C);
    chk("R2 A lo", jam, 32'h0000_A53C);
    bus_wr(3'd4, 8'h77);
    bus_wr(3'd3, 8'h12);
    chk("R2 B", jam, 32'h1277_A53C);
  endtask

  task automatic t_ctrl();
    bus_wr(3'd2, 8'h5A);
    chk("R3 A pulse", {30'h0, cwr}, 32'h1);
    chk("R3 A byte", {16'h0, ctrl}, 32'h005A);
    @(negedge clk);
    chk("R3 A pulse width", {30'h0, cwr}, 32'h0);
    bus_wr(3'd5, 8'hC3);
    chk("R3 B pulse", {30'h0, cwr}, 32'h2);
    chk("R3 B byte", {16'h0, ctrl}, 32'hC35A);
  endtask

  task automatic t_hold();
    logic [7:0] d;
    hold = 32'hDEAD_BEEF;
    bus_rd(3'd0, d); chk("R4 A hi", {24'h0, d}, 32'hBE);
    bus_rd(3'd1, d); chk("R4 A lo", {24'h0, d}, 32'hEF);
    bus_rd(3'd3, d); chk("R4 B hi", {24'h0, d}, 32'hDE);
    bus_rd(3'd4, d); chk("R4 B lo", {24'h0, d}, 32'hAD);
  endtask

  task automatic t_timeout();
    logic [7:0] d;
    ien = 2'b00;
    pulse_tmo(2'b01);
    bus_rd(3'd5, d); chk("R6 A flag no enable", {24'h0, d}, 32'h80);
    chk("R7 disabled", {31'h0, irq_n}, 32'h1);
    ien = 2'b01; #1;
    chk("R7 enabled", {31'h0, irq_n}, 32'h0);
    pulse_tmo(2'b10);
    bus_rd(3'd2, d); chk("R5 both flags", {24'h0, d}, 32'hC0);
    ien = 2'b00; #1;
    chk("R7 enable dropped", {31'h0, irq_n}, 32'h1);
    bus_rd(3'd2, d); chk("R7 flags kept", {24'h0, d}, 32'hC0);
    ien = 2'b11; #1;
  endtask

  task automatic t_clear();
    logic [7:0] d;
    bus_wr(3'd2, 8'h01);
    bus_rd(3'd2, d); chk("R8 A cleared only", {24'h0, d}, 32'h40);
    chk("R8 irq held by B", {31'h0, irq_n}, 32'h0);
    bus_wr(3'd5, 8'h02);
    bus_rd(3'd5, d); chk("R8 B cleared", {24'h0, d}, 32'h00);
    chk("R8 irq released", {31'h0, irq_n}, 32'h1);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; addr = 3'd5; wdata = 8'h9E; tmo = 2'b10;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0; tmo = '0;
    bus_rd(3'd5, d); chk("R9 set wins", {24'h0, d}, 32'h40);
    chk("R9 ctrl loaded", {16'h0, ctrl}, 32'h9E01);
    bus_wr(3'd5, 8'h9E);
  endtask

  task automatic t_reserved();
    logic [7:0] d;
    pulse_tmo(2'b01);
    bus_wr(3'd6, 8'hFF);
    chk("R10 no pulse", {30'h0, cwr}, 32'h0);
    bus_wr(3'd7, 8'h00);
    chk("R10 jam kept", jam, 32'h1277_A53C);
    chk("R10 ctrl kept", {16'h0, ctrl}, 32'h9E01);
    bus_rd(3'd2, d); chk("R10 flag kept", {24'h0, d}, 32'h80);
    bus_rd(3'd6, d); chk("R10 read 6", {24'h0, d}, 32'h0);
    bus_rd(3'd7, d); chk("R10 read 7", {24'h0, d}, 32'h0);
  endtask

  task automatic t_idle();
    @(negedge clk);
    rd = 1'b1; addr = 3'd2; #1;
    chk("R11 rd without cs", {24'h0, rdata}, 32'h0);
    rd = 1'b0; cs = 1'b1; #1;
    chk("R11 cs without rd", {24'h0, rdata}, 32'h0);
    cs = 1'b0;
    @(negedge clk);
    wr = 1'b1; addr = 3'd0; wdata = 8'h55;
    @(negedge clk);
    wr = 1'b0;
    chk("R11 wr without cs", jam, 32'h1277_A53C);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_jam();
    t_ctrl();
    t_hold();
    t_timeout();
    t_clear();
    t_collide();
    t_reserved();
    t_idle();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule